// File: doc/BRIEF.md
# Single-Wire Consumer-Control Bus Frame Receiver

This block watches the single open-drain wire of a consumer-electronics control bus and turns the pulses on it into frames. A one-microsecond tick enable sets every time window, so the block runs from any system clock. The block checks that a start pulse is well formed. It then samples each data bit a fixed time after that bit's falling edge and builds the bytes most significant bit first. The end-of-message flag is kept from the ninth slot of every byte.

The block also drives the wire through an open-drain pull-down output. In the acknowledge slot it holds the wire low when the frame's destination is one of the addresses it owns. When a bit period is too short, it holds the wire low for one and a half nominal bit periods to mark an error. A finished frame is presented as a byte array and a length, with a one-cycle valid pulse.

A transmitter that loses arbitration part-way through the first byte can hand over to this block. It gives a count of bits already on the wire and the first byte seen so far, and reception continues from the following bit.

Top module: `cec_frame_rx`

## Requirements
- R1: After a falling edge seen in idle, a rising edge that comes before T_START_LOW_MIN ticks drops the frame and returns to idle: no frame is delivered and the wire is never pulled low.
- R2: If the wire is still high more than T_START_MAX ticks after the start pulse's falling edge, the frame is dropped and no frame is delivered.
- R3: Each data bit is sampled T_SAMPLE ticks after its falling edge. The first eight slots of each byte fill that byte most significant bit first, and byte k appears at frame_data[8k+7:8k].
- R4: The ninth slot (slot 8) of each byte carries the end-of-message flag. When it is sampled, frame_len takes the number of bytes received so far, that byte included.
- R5: During a data bit, if the wire stays high more than T_BIT_MAX ticks after the previous falling edge, the frame is dropped. A frame whose last received byte had the end-of-message flag clear is never delivered.
- R6: A falling edge that comes fewer than T_BIT_MIN ticks after the previous data falling edge makes the block pull the wire low for T_LOW_DRIVE ticks. It then releases the wire and returns to idle without delivering a frame.
- R7: In the tenth slot (slot 9) the block pulls the wire low for T_ACK_LOW ticks only if the destination, bits [3:0] of the first byte, is set in own_mask and is not 15.
- R8: T_RISE ticks after the acknowledge falling edge, if the wire is high and end-of-message was set, frame_valid pulses for exactly one cycle. The block goes back to idle T_BIT_MIN ticks after that edge.
- R9: Bytes after the first MAX_BYTES are not stored, and frame_len stops at MAX_BYTES. Their bits still pass through the bit timing, and the acknowledge is still driven for them.
- R10: Whenever the block returns to idle, frame_len and every byte of frame_data are zero.
- R11: A pulse on resume_go, in any state, restarts reception as if the sample point of bit resume_cnt-1 (1..8) of the first byte had just passed. Byte 0 keeps only the upper resume_cnt bits of resume_byte, and the following bits are received normally.
- R12: After reset the wire is released, frame_valid is low and frame_len and frame_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-microsecond timing enable |
| line_in | input | 1 | Wire level, already synchronous to clk |
| own_mask | input | 16 | One bit per owned logical address |
| resume_go | input | 1 | Continue a frame handed over by the transmitter |
| resume_cnt | input | 4 | Bits of the first byte already on the wire (1..8) |
| resume_byte | input | 8 | First byte as far as it has been seen, MSB first |
| line_pull_low | output | 1 | Open-drain pull-down for the wire |
| frame_valid | output | 1 | One-cycle pulse: frame complete |
| frame_len | output | LEN_W | Bytes in the frame, at most MAX_BYTES |
| frame_data | output | MAX_BYTES*8 | Frame bytes, byte 0 in the low bits |

## Verification
The bound checker checks four rules on every cycle. The valid pulse lasts one cycle and only follows a high sample of the wire. The length never passes the byte limit. The buffer is empty in idle. The acknowledge pull-down appears only for an owned, non-broadcast destination. The rest can only be shown by the bench driving the wire: the timing windows on the start pulse and the bit period, the low-drive error pulse and its length, storage being dropped past the byte limit, and the hand-over from the transmitter.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START_LOW,
    ST_START_HIGH,
    ST_SAMPLE,
    ST_POST,
    ST_BIT_HIGH,
    ST_ACK,
    ST_FINISH,
    ST_LOW_DRIVE
  } rx_state_t;
endpackage

// File: rtl/cec_rx_line.sv
module cec_rx_line (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic fall
);
  logic line_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_s <= 1'b1;
      line_d <= 1'b1;
    end else begin
      line_s <= line_in;
      line_d <= line_s;
    end
  end

  assign fall = line_d & ~line_s;
endmodule

// File: rtl/cec_rx_elapsed.sv
module cec_rx_elapsed #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_n;

  always_comb begin
    count_n = count;
    if (load)
      count_n = load_val;
    else if (clr)
      count_n = '0;
    else if (tick && (count != {CNT_W{1'b1}}))
      count_n = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else
      count <= count_n;
  end
endmodule

// File: rtl/cec_rx_store.sv
module cec_rx_store #(
  parameter int MAX_BYTES = 16,
  parameter int IDX_W     = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [2:0]             wr_pos,
  input  logic                   wr_val,
  input  logic                   pre_en,
  input  logic [7:0]             pre_byte,
  input  logic [3:0]             pre_cnt,
  output logic [MAX_BYTES*8-1:0] data
);
  logic [7:0] pre_mask;
  assign pre_mask = ~(8'hFF >> pre_cnt);

  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_byte
    logic [7:0] byte_q;
    logic [7:0] pre_val;
    assign pre_val = (k == 0) ? (pre_byte & pre_mask) : 8'h00;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        byte_q <= 8'h00;
      else if (clr)
        byte_q <= 8'h00;
      else if (pre_en)
        byte_q <= pre_val;
      else if (wr_en && (wr_idx == IDX_W'(k)))
        byte_q[wr_pos] <= wr_val;
    end

    assign data[k*8 +: 8] = byte_q;
  end
endmodule

// File: rtl/cec_frame_rx.sv
module cec_frame_rx
  import cec_rx_pkg::*;
#(
  parameter int MAX_BYTES       = 16,
  parameter int T_START_LOW_MIN = 3500,
  parameter int T_START_MAX     = 4700,
  parameter int T_SAMPLE        = 850,
  parameter int T_RISE          = 1750,
  parameter int T_BIT_MIN       = 2050,
  parameter int T_BIT_MAX       = 2750,
  parameter int T_ACK_LOW       = 1500,
  parameter int T_LOW_DRIVE     = 3600,
  localparam int LEN_W          = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_us,
  input  logic                   line_in,
  input  logic [15:0]            own_mask,
  input  logic                   resume_go,
  input  logic [3:0]             resume_cnt,
  input  logic [7:0]             resume_byte,
  output logic                   line_pull_low,
  output logic                   frame_valid,
  output logic [LEN_W-1:0]       frame_len,
  output logic [MAX_BYTES*8-1:0] frame_data
);
  localparam int T_TOP_A = (T_START_MAX > T_BIT_MAX) ? T_START_MAX : T_BIT_MAX;
  localparam int T_TOP   = (T_TOP_A > T_LOW_DRIVE) ? T_TOP_A : T_LOW_DRIVE;
  localparam int CNT_W   = $clog2(T_TOP + 2);

  localparam logic [CNT_W-1:0] LIM_START_LOW = CNT_W'(T_START_LOW_MIN);
  localparam logic [CNT_W-1:0] LIM_START_MAX = CNT_W'(T_START_MAX);
  localparam logic [CNT_W-1:0] LIM_SAMPLE    = CNT_W'(T_SAMPLE);
  localparam logic [CNT_W-1:0] LIM_RISE      = CNT_W'(T_RISE);
  localparam logic [CNT_W-1:0] LIM_BIT_MIN   = CNT_W'(T_BIT_MIN);
  localparam logic [CNT_W-1:0] LIM_BIT_MAX   = CNT_W'(T_BIT_MAX);
  localparam logic [CNT_W-1:0] LIM_ACK_LOW   = CNT_W'(T_ACK_LOW);
  localparam logic [CNT_W-1:0] LIM_LOW_DRIVE = CNT_W'(T_LOW_DRIVE);
  localparam logic [LEN_W-1:0] BYTE_CAP      = LEN_W'(MAX_BYTES);

  rx_state_t        st_q, st_n;
  logic             line_s, fall;
  logic [CNT_W-1:0] elapsed;
  logic [3:0]       slot_q;
  logic [LEN_W-1:0] idx_q, len_q, len_n;
  logic             eom_q, ack_me_q, valid_q;
  logic             cnt_clr, to_idle, smp, ack_end, enter_ack, deliver;
  logic             ack_hit, wr_en;
  logic [3:0]       dest;

  cec_rx_line u_line (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_in(line_in),
    .line_s (line_s),
    .fall   (fall)
  );

  cec_rx_elapsed #(.CNT_W(CNT_W)) u_elapsed (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_us),
    .clr     (cnt_clr),
    .load    (resume_go),
    .load_val(LIM_SAMPLE),
    .count   (elapsed)
  );

  assign wr_en = smp && (slot_q < 4'd8) && (idx_q < BYTE_CAP);

  cec_rx_store #(.MAX_BYTES(MAX_BYTES), .IDX_W(LEN_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (to_idle),
    .wr_en   (wr_en),
    .wr_idx  (idx_q),
    .wr_pos  (3'd7 - slot_q[2:0]),
    .wr_val  (line_s),
    .pre_en  (resume_go),
    .pre_byte(resume_byte),
    .pre_cnt (resume_cnt),
    .data    (frame_data)
  );

  assign dest    = frame_data[3:0];
  assign ack_hit = own_mask[dest] && (dest != 4'hF);
  assign len_n   = (idx_q >= BYTE_CAP) ? BYTE_CAP : idx_q + LEN_W'(1);

  // Next-state and strobes
  always_comb begin
    st_n      = st_q;
    cnt_clr   = 1'b0;
    to_idle   = 1'b0;
    smp       = 1'b0;
    ack_end   = 1'b0;
    enter_ack = 1'b0;
    deliver   = 1'b0;
    if (resume_go) begin
      st_n = ST_POST;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (fall) begin
            st_n    = ST_START_LOW;
            cnt_clr = 1'b1;
          end
        end
        ST_START_LOW: begin
          if (line_s) begin
            if (elapsed < LIM_START_LOW) to_idle = 1'b1;
            else                         st_n    = ST_START_HIGH;
          end
        end
        ST_START_HIGH: begin
          if (line_s) begin
            if (elapsed > LIM_START_MAX) to_idle = 1'b1;
          end else begin
            st_n    = ST_SAMPLE;
            cnt_clr = 1'b1;
          end
        end
        ST_SAMPLE: begin
          if (elapsed >= LIM_SAMPLE) begin
            smp  = 1'b1;
            st_n = ST_POST;
          end
        end
        ST_POST: begin
          if (elapsed >= LIM_RISE) st_n = ST_BIT_HIGH;
        end
        ST_BIT_HIGH: begin
          if (line_s) begin
            if (elapsed > LIM_BIT_MAX) to_idle = 1'b1;
          end else if (elapsed < LIM_BIT_MIN) begin
            st_n    = ST_LOW_DRIVE;
            cnt_clr = 1'b1;
          end else begin
            cnt_clr = 1'b1;
            if (slot_q == 4'd9) begin
              st_n      = ST_ACK;
              enter_ack = 1'b1;
            end else begin
              st_n = ST_SAMPLE;
            end
          end
        end
        ST_ACK: begin
          if (elapsed >= LIM_RISE) begin
            if (line_s && eom_q) begin
              deliver = 1'b1;
              st_n    = ST_FINISH;
            end else begin
              ack_end = 1'b1;
              st_n    = ST_BIT_HIGH;
            end
          end
        end
        ST_FINISH: begin
          if (elapsed >= LIM_BIT_MIN) to_idle = 1'b1;
        end
        ST_LOW_DRIVE: begin
          if (elapsed >= LIM_LOW_DRIVE) to_idle = 1'b1;
        end
        default: to_idle = 1'b1;
      endcase
      if (to_idle) st_n = ST_IDLE;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      slot_q   <= 4'd0;
      idx_q    <= '0;
      len_q    <= '0;
      eom_q    <= 1'b0;
      ack_me_q <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      valid_q <= deliver;
      if (resume_go) begin
        slot_q   <= resume_cnt;
        idx_q    <= '0;
        len_q    <= '0;
        eom_q    <= 1'b0;
        ack_me_q <= 1'b0;
      end else if (to_idle) begin
        slot_q   <= 4'd0;
        idx_q    <= '0;
        len_q    <= '0;
        eom_q    <= 1'b0;
        ack_me_q <= 1'b0;
      end else begin
        if (smp) begin
          if (slot_q == 4'd8) begin
            eom_q <= line_s;
            len_q <= len_n;
          end
          slot_q <= slot_q + 4'd1;
        end
        if (enter_ack) ack_me_q <= ack_hit;
        if (ack_end) begin
          slot_q <= 4'd0;
          if (idx_q < BYTE_CAP) idx_q <= idx_q + LEN_W'(1);
        end
      end
    end
  end

  assign line_pull_low = ((st_q == ST_ACK) && ack_me_q && (elapsed < LIM_ACK_LOW))
                       || (st_q == ST_LOW_DRIVE);
  assign frame_valid   = valid_q;
  assign frame_len     = len_q;
endmodule

// File: rtl/cec_frame_rx_chk.sv
module cec_frame_rx_chk
  import cec_rx_pkg::*;
#(
  parameter int MAX_BYTES = 16,
  parameter int LEN_W     = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   line_s,
  input rx_state_t              st,
  input logic [15:0]            own_mask,
  input logic                   line_pull_low,
  input logic                   frame_valid,
  input logic [LEN_W-1:0]       frame_len,
  input logic [MAX_BYTES*8-1:0] frame_data
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) frame_valid |=> !frame_valid); // R8
  AST_VALID_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) frame_valid |-> $past(line_s)); // R8
  AST_VALID_IN_FINISH: assert property (@(posedge clk) disable iff (!rst_n) frame_valid |-> (st == ST_FINISH)); // R8
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n) frame_len <= LEN_W'(MAX_BYTES)); // R9
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (st == ST_IDLE) |-> ((frame_len == '0) && (frame_data == '0))); // R10
  AST_ACK_OWNED: assert property (@(posedge clk) disable iff (!rst_n) (line_pull_low && (st == ST_ACK)) |-> (own_mask[frame_data[3:0]] && (frame_data[3:0] != 4'hF))); // R7
endmodule

bind cec_frame_rx cec_frame_rx_chk #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .line_s       (line_s),
  .st           (st_q),
  .own_mask     (own_mask),
  .line_pull_low(line_pull_low),
  .frame_valid  (frame_valid),
  .frame_len    (frame_len),
  .frame_data   (frame_data)
);

// File: tb/cec_frame_rx_bench.sv
module cec_frame_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MB = 4;
  localparam int LW = $clog2(MB + 1);

  logic clk = 1'b0;
  logic rst_n, drv, bus, resume_go;
  logic [15:0] own_mask;
  logic [3:0]  resume_cnt;
  logic [7:0]  resume_byte;
  logic        pull, frame_valid;
  logic [LW-1:0]   frame_len;
  logic [MB*8-1:0] frame_data;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign bus = drv & ~pull;

  cec_frame_rx #(
    .MAX_BYTES(MB), .T_START_LOW_MIN(70), .T_START_MAX(94), .T_SAMPLE(17),
    .T_RISE(35), .T_BIT_MIN(41), .T_BIT_MAX(55), .T_ACK_LOW(30), .T_LOW_DRIVE(72)
  ) u_cec_frame_rx (
    .clk(clk), .rst_n(rst_n), .tick_us(1'b1), .line_in(bus), .own_mask(own_mask),
    .resume_go(resume_go), .resume_cnt(resume_cnt), .resume_byte(resume_byte),
    .line_pull_low(pull), .frame_valid(frame_valid), .frame_len(frame_len),
    .frame_data(frame_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int got_cnt = 0;
  logic [LW-1:0]   got_len;
  logic [MB*8-1:0] got_data;
  bit pull_seen;
  logic [7:0] txb [0:7];
  bit ack_seen [0:7];

  always @(negedge clk) begin
    if (frame_valid) begin
      got_cnt  = got_cnt + 1;
      got_len  = frame_len;
      got_data = frame_data;
    end
    if (pull) pull_seen = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    drv = 1'b0; wait_n(b ? 12 : 30);
    drv = 1'b1; wait_n(b ? 36 : 18);
  endtask

  task automatic send_ack_slot(input int i);
    drv = 1'b0; wait_n(12);
    drv = 1'b1; wait_n(8);
    ack_seen[i] = ~bus;
    wait_n(20);
    chk("R7 acknowledge released", 64'(bus), 64'd1);
    wait_n(8);
  endtask

  task automatic send_start(input int low, input int high);
    drv = 1'b0; wait_n(low);
    drv = 1'b1; wait_n(high);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic eom, input int i);
    for (int j = 7; j >= 0; j--) send_bit(v[j]);
    send_bit(eom);
    send_ack_slot(i);
  endtask

  task automatic send_frame(input int n);
    send_start(74, 16);
    for (int i = 0; i < n; i++) send_byte(txb[i], (i == n - 1), i);
    wait_n(30);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int c0;
    rst_n = 1'b0; drv = 1'b1; resume_go = 1'b0; resume_cnt = 4'd0; resume_byte = 8'h00;
    own_mask = 16'hA5C3;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3);

    // R12: reset state
    chk("R12 pull after reset", 64'(pull), 64'd0);
    chk("R12 valid after reset", 64'(frame_valid), 64'd0);
    chk("R12 len after reset", 64'(frame_len), 64'd0);
    chk("R12 data after reset", 64'(frame_data), 64'd0);

    // R7 sweep over every destination, one byte each
    for (int d = 0; d < 16; d++) begin
      txb[0] = {4'h3, 4'(d)};
      c0 = got_cnt;
      send_frame(1);
      chk("R7 acknowledge per destination", 64'(ack_seen[0]), 64'(own_mask[d] && (d != 15)));
      chk("R8 one delivery", 64'(got_cnt), 64'(c0 + 1));
      chk("R3 byte assembled", 64'(got_data[7:0]), 64'(txb[0]));
      chk("R4 length one", 64'(got_len), 64'd1);
    end

    // R3/R4: two-byte frame
    txb[0] = 8'h4A; txb[1] = 8'h96;
    c0 = got_cnt;
    send_frame(2);
    chk("R4 length two", 64'(got_len), 64'd2);
    chk("R3 two bytes", 64'(got_data), 64'h0000964A);
    chk("R7 ack byte 1", 64'(ack_seen[1]), 64'd1);
    chk("R8 delivered once", 64'(got_cnt), 64'(c0 + 1));

    // R9: six bytes into a four-byte store
    txb[0] = 8'h1A; txb[1] = 8'h22; txb[2] = 8'h33;
    txb[3] = 8'h44; txb[4] = 8'h55; txb[5] = 8'h66;
    send_frame(6);
    chk("R9 length capped", 64'(got_len), 64'd4);
    chk("R9 stored bytes", 64'(got_data), 64'h4433221A);
    chk("R9 ack past limit", 64'(ack_seen[5]), 64'd1);

    // R10: buffer cleared before the next frame
    txb[0] = 8'h3B;
    send_frame(1);
    chk("R10 old bytes cleared", 64'(got_data), 64'h0000003B);
    chk("R7 unowned not acked", 64'(ack_seen[0]), 64'd0);

    // R5: last byte without end-of-message
    c0 = got_cnt;
    send_start(74, 16);
    send_byte(8'h31, 1'b0, 0);
    wait_n(100);
    chk("R5 no delivery without eom", 64'(got_cnt), 64'(c0));

    // R1: start low too short
    c0 = got_cnt; pull_seen = 1'b0;
    send_start(60, 30);
    send_byte(8'h3A, 1'b1, 0);
    wait_n(100);
    chk("R1 short start no frame", 64'(got_cnt), 64'(c0));
    chk("R1 short start no pull", 64'(pull_seen), 64'd0);

    // R2: start pulse too long
    c0 = got_cnt;
    send_start(74, 26);
    send_byte(8'h3A, 1'b1, 0);
    wait_n(100);
    chk("R2 long start no frame", 64'(got_cnt), 64'(c0));

    // R5: bit period too long
    c0 = got_cnt;
    send_start(74, 16);
    for (int j = 0; j < 4; j++) send_bit(1'b0);
    wait_n(12);
    for (int j = 0; j < 4; j++) send_bit(1'b1);
    send_bit(1'b1);
    send_ack_slot(0);
    wait_n(100);
    chk("R5 bit timeout no frame", 64'(got_cnt), 64'(c0));

    // R6: bit period too short
    c0 = got_cnt;
    send_start(74, 16);
    send_bit(1'b1);
    send_bit(1'b1);
    drv = 1'b0; wait_n(12);
    drv = 1'b1; wait_n(23);
    drv = 1'b0; wait_n(10);
    chk("R6 low drive starts", 64'(pull), 64'd1);
    drv = 1'b1; wait_n(50);
    chk("R6 low drive held", 64'(pull), 64'd1);
    chk("R6 wire low", 64'(bus), 64'd0);
    wait_n(25);
    chk("R6 low drive ends", 64'(pull), 64'd0);
    chk("R6 wire released", 64'(bus), 64'd1);
    wait_n(60);
    chk("R6 no frame", 64'(got_cnt), 64'(c0));

    // R11: hand-over after three bits of the first byte
    c0 = got_cnt;
    resume_cnt = 4'd3; resume_byte = 8'hBF; resume_go = 1'b1;
    wait_n(1);
    resume_go = 1'b0;
    wait_n(30);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    send_bit(1'b1);
    send_ack_slot(0);
    wait_n(30);
    chk("R11 resumed frame delivered", 64'(got_cnt), 64'(c0 + 1));
    chk("R11 resumed byte", 64'(got_data[7:0]), 64'hA6);
    chk("R11 resumed ack", 64'(ack_seen[0]), 64'd1);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule